// File: doc/BRIEF.md
# Shared-Bus Extended Load Sequencer

This block sequences one instruction class of a small CPU whose program bytes and data bytes live in a single memory. That memory is reached through one address bus and one byte-wide read-data bus. The only instruction it executes is a load of the accumulator from a 16-bit absolute address. That instruction is three bytes long: an opcode byte, then the high byte of the target address, then the low byte.

Every byte moves over the same bus, one per clock cycle and strictly in order. The first cycle fetches the opcode at the program counter. The next two cycles fetch the address bytes from the two following locations. The fourth cycle places the assembled target address on the bus and captures the returned byte into the accumulator. A load therefore always costs four bus cycles. The next instruction's opcode fetch follows with no idle cycle.

Memory is assumed to answer within the cycle: the byte on the read-data input is taken at the clock edge that ends the cycle in which its address was presented. An opcode the block does not recognise stops it until reset.

Top module: `shared_bus_lda_seq`

## Requirements
- R1: While and after synchronous active-high reset, `bus_addr` equals the start address (default 0x0100), `bus_rd` is 1, `acc` is 0x00, and `done` and `illegal` are 0. The first cycle after reset is an opcode fetch.
- R2: In the first cycle of an instruction, `bus_addr` equals the program counter and `bus_rd` is 1. The byte read is taken as the opcode, and only the value 0xB6 continues the load sequence.
- R3: In the second and third cycles, `bus_addr` equals the program counter plus 1 and plus 2. The byte read in the second cycle becomes address bits 15:8 and the byte read in the third becomes bits 7:0.
- R4: In the fourth cycle, `bus_addr` equals the 16-bit address assembled from those two bytes, and `bus_rd` is 1.
- R5: `acc` takes the byte read in the fourth cycle and keeps its value in every other cycle.
- R6: `done` is 1 for exactly one cycle: the cycle right after the fourth bus cycle, which is also the next opcode fetch.
- R7: Instructions run back to back with no gap. Each takes exactly four cycles, and the next opcode is fetched from the previous opcode address plus 3.
- R8: The program counter wraps from 0xFFFF to 0x0000.
- R9: When an opcode other than 0xB6 is read, `illegal` is 1 from the next cycle on, and `bus_rd` is 0. While halted, `bus_addr` stays at the address of the rejected opcode, `acc` is unchanged and `done` is 0. This lasts until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | output | 16 | Shared address bus |
| bus_rdata | input | 8 | Byte returned by memory for the current address |
| bus_rd | output | 1 | Read strobe, high in every active bus cycle |
| acc | output | 8 | Accumulator |
| done | output | 1 | One-cycle pulse after a load completes |
| illegal | output | 1 | Sticky flag for an unrecognised opcode |

## Verification
The main function is driven with a program of eight consecutive loads whose target addresses differ in every byte pattern. The patterns include all-zero and near-all-ones addresses, a high byte and low byte that are not equal, and a target that points back at the program's own first opcode. Together they separate a swapped high/low byte order and a wrong program-counter step from a correct fetch. They also catch a load that returns the wrong location's byte. A second instance starts at 0xFFFE so that its operand fetch crosses the top of the address space. That instance then meets an unrecognised byte and halts. The main program ends on a rejected opcode, and reset is applied both while halted and in the middle of an instruction.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;
  // Bus phase of the load sequence; ST_HALT is terminal until reset.
  typedef enum logic [2:0] {
    ST_OPC  = 3'd0,
    ST_ADH  = 3'd1,
    ST_ADL  = 3'd2,
    ST_EXE  = 3'd3,
    ST_HALT = 3'd4
  } seq_state_t;
endpackage

// File: rtl/ldseq_ctrl.sv
module ldseq_ctrl
  import ldseq_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OPC_LDA = 'hB6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rdata,
  output logic              pc_step,
  output logic              hi_take,
  output logic              lo_take,
  output logic              acc_take,
  output logic              ea_phase,
  output logic              bus_active,
  output logic              done,
  output logic              illegal
);
  localparam logic [DATA_W-1:0] LOAD_CODE = DATA_W'(OPC_LDA);

  function automatic logic is_load(input logic [DATA_W-1:0] code);
    return code == LOAD_CODE;
  endfunction

  seq_state_t state_q, state_d;
  logic       done_q;
  logic       opc_ok;

  assign opc_ok = is_load(rdata);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPC:  state_d = opc_ok ? ST_ADH : ST_HALT;
      ST_ADH:  state_d = ST_ADL;
      ST_ADL:  state_d = ST_EXE;
      ST_EXE:  state_d = ST_OPC;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OPC;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= acc_take;
    end
  end

  assign pc_step    = ((state_q == ST_OPC) && opc_ok) || (state_q == ST_ADH) || (state_q == ST_ADL);
  assign hi_take    = (state_q == ST_ADH);
  assign lo_take    = (state_q == ST_ADL);
  assign acc_take   = (state_q == ST_EXE);
  assign ea_phase   = (state_q == ST_EXE);
  assign bus_active = (state_q != ST_HALT);
  assign illegal    = (state_q == ST_HALT);
  assign done       = done_q;

  // R6: completion pulse lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9: halt is sticky and silences the bus
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst) illegal |=> (illegal && !bus_active));
  // R7: execute cycle is followed directly by an opcode fetch
  p_exe_then_opc_r7: assert property (@(posedge clk) disable iff (rst) acc_take |=> (state_q == ST_OPC));
  // R6: pulse only follows an execute cycle
  p_done_after_exe_r6: assert property (@(posedge clk) disable iff (rst) !acc_take |=> !done);
endmodule

// File: rtl/ldseq_pc.sv
module ldseq_pc #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned START_ADDR = 'h0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [ADDR_W-1:0] pc
);
  // Modular increment: the top of the space rolls to zero (R8).
  function automatic logic [ADDR_W-1:0] pc_after(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= ADDR_W'(START_ADDR);
    else if (step) pc_q <= pc_after(pc_q);
  end

  assign pc = pc_q;

  // R9: counter frozen whenever no instruction byte is consumed
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(pc_q));
endmodule

// File: rtl/ldseq_operand.sv
module ldseq_operand #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   rdata,
  input  logic                hi_take,
  input  logic                lo_take,
  input  logic                acc_take,
  output logic [2*DATA_W-1:0] ea,
  output logic [DATA_W-1:0]   acc
);
  // High byte arrives first and lands in the upper half (R3).
  function automatic logic [2*DATA_W-1:0] join_addr(input logic [DATA_W-1:0] hi,
                                                    input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [DATA_W-1:0] hi_q, lo_q, acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      acc_q <= '0;
    end else begin
      if (hi_take)  hi_q  <= rdata;
      if (lo_take)  lo_q  <= rdata;
      if (acc_take) acc_q <= rdata;
    end
  end

  assign ea  = join_addr(hi_q, lo_q);
  assign acc = acc_q;

  // R5: accumulator changes only on the execute cycle
  p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst) !acc_take |=> $stable(acc_q));
  // R5: accumulator captures the bus byte of the execute cycle
  p_acc_load_r5: assert property (@(posedge clk) disable iff (rst) acc_take |=> (acc_q == $past(rdata)));
endmodule

// File: rtl/shared_bus_lda_seq.sv
module shared_bus_lda_seq #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned START_ADDR = 'h0100,
  parameter int unsigned OPC_LDA    = 'hB6
) (
  input  logic                clk,
  input  logic                rst,
  output logic [2*DATA_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rd,
  output logic [DATA_W-1:0]   acc,
  output logic                done,
  output logic                illegal
);
  localparam int unsigned ADDR_W = 2 * DATA_W;

  logic              pc_step, hi_take, lo_take, acc_take, ea_phase, bus_active;
  logic [ADDR_W-1:0] pc, ea;

  ldseq_ctrl #(.DATA_W(DATA_W), .OPC_LDA(OPC_LDA)) u_ctrl (
    .clk(clk), .rst(rst), .rdata(bus_rdata),
    .pc_step(pc_step), .hi_take(hi_take), .lo_take(lo_take),
    .acc_take(acc_take), .ea_phase(ea_phase), .bus_active(bus_active),
    .done(done), .illegal(illegal)
  );

  ldseq_pc #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_pc (
    .clk(clk), .rst(rst), .step(pc_step), .pc(pc)
  );

  ldseq_operand #(.DATA_W(DATA_W)) u_opnd (
    .clk(clk), .rst(rst), .rdata(bus_rdata),
    .hi_take(hi_take), .lo_take(lo_take), .acc_take(acc_take),
    .ea(ea), .acc(acc)
  );

  // Address and strobe come only from registered state, so they hold for the whole cycle.
  assign bus_addr = ea_phase ? ea : pc;
  assign bus_rd   = bus_active;

  // R9: address frozen while halted
  p_halt_addr_r9: assert property (@(posedge clk) disable iff (rst) illegal |=> $stable(bus_addr));
  // R7: after the execute cycle the bus returns to the program counter
  p_return_to_pc_r7: assert property (@(posedge clk) disable iff (rst) ea_phase |=> (bus_addr == pc));
endmodule

// File: tb/sim_shared_bus_lda_seq.sv
module sim_shared_bus_lda_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr0, addr1;
  logic [7:0]  rdata0, rdata1, acc0, acc1;
  logic        rd0, rd1, done0, done1, ill0, ill1;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  // Stimulus/expected table: {target address, byte expected in acc}.
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    24'h1234_7C, 24'h0000_5A, 24'hFFFE_5B, 24'h0100_B6,
    24'h8001_DB, 24'h00FF_A5, 24'h3C00_66, 24'h4281_99
  };

  function automatic logic [7:0] filler(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  // Main program: NV loads from 0x0100, then an unknown opcode 0xB7.
  function automatic logic [7:0] mem0(input logic [15:0] a);
    int idx;
    if (a >= 16'h0100 && a < 16'h0100 + 16'(3*NV)) begin
      idx = int'(a - 16'h0100);
      case (idx % 3)
        0:       return 8'hB6;
        1:       return VEC[idx/3][23:16];
        default: return VEC[idx/3][15:8];
      endcase
    end
    if (a == 16'h0100 + 16'(3*NV)) return 8'hB7;
    return filler(a);
  endfunction

  // Wrap program: load 0x1234 starting at 0xFFFE.
  function automatic logic [7:0] mem1(input logic [15:0] a);
    if (a == 16'hFFFE) return 8'hB6;
    if (a == 16'hFFFF) return 8'h12;
    if (a == 16'h0000) return 8'h34;
    return filler(a);
  endfunction

  assign rdata0 = mem0(addr0);
  assign rdata1 = mem1(addr1);

  shared_bus_lda_seq u0 (
    .clk(clk), .rst(rst), .bus_addr(addr0), .bus_rdata(rdata0), .bus_rd(rd0),
    .acc(acc0), .done(done0), .illegal(ill0)
  );

  shared_bus_lda_seq #(.START_ADDR('hFFFE)) u1 (
    .clk(clk), .rst(rst), .bus_addr(addr1), .bus_rdata(rdata1), .bus_rd(rd1),
    .acc(acc1), .done(done1), .illegal(ill1)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [15:0] pc;
    logic [7:0]  prev_acc;

    // R1: state during reset
    repeat (3) step();
    chk("R1", "addr in reset", 32'(addr0), 32'h0100);
    chk("R1", "rd in reset", 32'(rd0), 1);
    chk("R1", "acc in reset", 32'(acc0), 0);
    chk("R1", "done in reset", 32'(done0), 0);
    chk("R1", "illegal in reset", 32'(ill0), 0);
    chk("R1", "u1 start addr", 32'(addr1), 32'hFFFE);
    rst = 1'b0;

    prev_acc = 8'h00;
    for (int k = 0; k < NV; k++) begin
      pc = 16'h0100 + 16'(3*k);
      // cycle 1: opcode fetch
      chk("R2", "opcode addr", 32'(addr0), 32'(pc));
      chk("R2", "opcode rd", 32'(rd0), 1);
      if (k > 0) begin
        chk("R6", "done at next fetch", 32'(done0), 1);
        chk("R5", "acc after load", 32'(acc0), 32'(VEC[k-1][7:0]));
      end else begin
        chk("R6", "no done before first load", 32'(done0), 0);
      end
      if (k == 0) chk("R8", "u1 opcode addr", 32'(addr1), 32'hFFFE);
      if (k == 1) begin
        chk("R8", "u1 next opcode after wrap", 32'(addr1), 32'h0001);
        chk("R5", "u1 acc", 32'(acc1), 32'h7C);
        chk("R6", "u1 done", 32'(done1), 1);
      end
      step();
      // cycle 2: high address byte
      chk("R3", "high byte addr", 32'(addr0), 32'(pc + 16'd1));
      chk("R6", "done drops", 32'(done0), 0);
      if (k == 0) chk("R8", "u1 high byte addr", 32'(addr1), 32'hFFFF);
      if (k == 1) begin
        chk("R9", "u1 halted", 32'(ill1), 1);
        chk("R9", "u1 rd off", 32'(rd1), 0);
      end
      step();
      // cycle 3: low address byte
      chk("R3", "low byte addr", 32'(addr0), 32'(pc + 16'd2));
      chk("R5", "acc holds", 32'(acc0), 32'(prev_acc));
      if (k == 0) chk("R8", "u1 low byte addr wraps", 32'(addr1), 32'h0000);
      step();
      // cycle 4: data access at assembled address
      chk("R4", "effective addr", 32'(addr0), 32'(VEC[k][23:8]));
      chk("R4", "data rd", 32'(rd0), 1);
      if (k == 0) chk("R4", "u1 effective addr", 32'(addr1), 32'h1234);
      step();
      prev_acc = VEC[k][7:0];
    end

    // Unknown opcode at 0x0118
    chk("R7", "fetch after last load", 32'(addr0), 32'h0118);
    chk("R5", "last acc", 32'(acc0), 32'h99);
    step();
    for (int i = 0; i < 4; i++) begin
      chk("R9", "illegal set", 32'(ill0), 1);
      chk("R9", "rd off", 32'(rd0), 0);
      chk("R9", "addr frozen", 32'(addr0), 32'h0118);
      chk("R9", "acc kept", 32'(acc0), 32'h99);
      chk("R9", "no done", 32'(done0), 0);
      step();
    end

    // Reset out of halt
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1", "illegal cleared", 32'(ill0), 0);
    chk("R1", "addr restart", 32'(addr0), 32'h0100);
    chk("R1", "acc cleared", 32'(acc0), 0);
    chk("R1", "rd back on", 32'(rd0), 1);

    // Reset in the middle of an instruction
    step();
    step();
    chk("R3", "mid-instr low byte addr", 32'(addr0), 32'h0102);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1", "mid-instr reset addr", 32'(addr0), 32'h0100);
    step(); step(); step();
    chk("R4", "rerun effective addr", 32'(addr0), 32'h1234);
    step();
    chk("R5", "rerun acc", 32'(acc0), 32'h7C);
    chk("R6", "rerun done", 32'(done0), 1);
    chk("R7", "rerun next fetch", 32'(addr0), 32'h0103);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule